// File: doc/BRIEF.md
# Zero-Cross Deferred Control Latch

This block receives a control word over a three-wire serial link made of a chip enable, a shift clock and a data line. It applies the word's payload to an audio path at a moment when the signal passes through zero, so that the change makes little audible noise. The word has three parts. The mode bits and the detection-point bits take effect as soon as the transfer ends. The payload either takes effect at once or waits for a zero-crossing event.

The detection-point bits drive a one-hot select for an external comparator multiplexer. That multiplexer chooses where in the signal chain crossings are watched: after volume, tone or fader, or at the source selector output. The comparator's result comes back as a one-cycle pulse, synchronous to the system clock. If no pulse arrives within a programmable number of clock cycles, the pending payload is applied anyway. Each application produces a one-cycle strobe. The applied payload is held on a plain output. The outputs are levels plus a strobe, with no back-pressure, because the audio path must accept a change whenever it is applied.

Top module: `zcl_latch_top`

## Requirements
- R1: After reset the outputs are: applied payload 0, detection select 4'b1000 (selector output), zero-cross mode flag 0, apply strobe 0.
- R2: While chip enable is high, each rising edge of the shift clock shifts in one data bit, MSB first. When chip enable goes low, the last 14 bits form the word. Bits [13:6] are the payload, bits [5:4] are the mode, and bits [3:0] are the detection select.
- R3: On the 4th clock edge after chip enable goes low, the detection select and mode flag are updated. Select bit 0 means the volume point, bit 1 tone, bit 2 fader and bit 3 selector output. Any select value that is not one-hot gives 4'b1000. The mode flag is 1 when and only when the mode bits are 2'b00.
- R4: When the mode bits are not 2'b00, the payload is applied with a strobe on that same 4th edge.
- R5: In zero-cross mode the payload stays pending. It is applied on the first edge after the capture edge at which the crossing pulse is high. A pulse sampled on or before the capture edge has no effect.
- R6: If no crossing comes, a pending payload is applied on the L-th edge after the capture edge, where L is the timeout input. The values 0 and 1 both give one edge.
- R7: The apply strobe lasts exactly one cycle for each applied word. The applied payload output changes only on the edge that raises the strobe.
- R8: A transfer that completes while a payload is pending replaces that payload and restarts the timeout from its own capture edge.
- R9: Crossing pulses while nothing is pending cause no strobe and leave the applied payload unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Serial chip enable; its falling edge ends a transfer |
| cl_i | input | 1 | Serial shift clock |
| di_i | input | 1 | Serial data |
| zc_pulse_i | input | 1 | Crossing pulse from the selected comparator |
| timeout_i | input | 24 | Timeout in clock cycles for a pending payload |
| det_point_o | output | 4 | One-hot comparator input select |
| zc_mode_o | output | 1 | Zero-cross wait mode is active |
| apply_stb_o | output | 1 | One-cycle strobe when a payload is applied |
| payload_o | output | 8 | Currently applied payload |

## Verification
A wrong internal state shows up at the ports in a fixed number of cycles. A bad bit count or misaligned shift register puts a wrong payload or select on the outputs four edges after chip enable falls. A stuck pending flag shows as a strobe that is missing, repeated or early. A timer that does not restart shows as a strobe that comes too early when a second transfer replaces a pending one. The bench measures the exact cycle of every strobe against latencies it computes itself. It sweeps all select codes, a range of timeouts and every crossing-pulse position around the capture edge.

// File: rtl/zcl_pkg.sv
package zcl_pkg;
  localparam int SEL_W  = 4;
  localparam int MODE_W = 2;

  // One-hot detection points, bit position = comparator mux input
  localparam logic [SEL_W-1:0] PT_VOLUME = 4'b0001;
  localparam logic [SEL_W-1:0] PT_TONE   = 4'b0010;
  localparam logic [SEL_W-1:0] PT_FADER  = 4'b0100;
  localparam logic [SEL_W-1:0] PT_SOURCE = 4'b1000;

  localparam logic [MODE_W-1:0] MODE_ZC_WAIT = 2'b00;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [SEL_W-1:0]  sel;
  } ctl_fields_t;

  function automatic logic [SEL_W-1:0] decode_point(input logic [SEL_W-1:0] raw);
    if ($countones(raw) == 1) return raw;
    return PT_SOURCE;
  endfunction
endpackage

// File: rtl/zcl_sync.sv
module zcl_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/zcl_serial_rx.sv
module zcl_serial_rx #(
  parameter int FRAME_W = 14,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_i,
  input  logic               cl_i,
  input  logic               di_i,
  output logic               frame_vld_o,
  output logic [FRAME_W-1:0] frame_o
);
  logic [2:0] raw_in, sync_in;
  logic       ce_s, cl_s, di_s;
  logic       ce_d, cl_d;
  logic [FRAME_W-1:0] shift_q;

  assign raw_in = {ce_i, cl_i, di_i};

  zcl_sync #(.WIDTH(3), .STAGES(SYNC_N)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_in),
    .q_o  (sync_in)
  );

  assign {ce_s, cl_s, di_s} = sync_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_d <= 1'b0;
      cl_d <= 1'b0;
    end else begin
      ce_d <= ce_s;
      cl_d <= cl_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else if (ce_s && cl_s && !cl_d) shift_q <= {shift_q[FRAME_W-2:0], di_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_vld_o <= 1'b0;
      frame_o     <= '0;
    end else begin
      frame_vld_o <= ce_d && !ce_s;
      if (ce_d && !ce_s) frame_o <= shift_q;
    end
  end

  // R2: a transfer end is a single-cycle event
  p_frame_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld_o |=> !frame_vld_o);
  // R2: the word is only released with chip enable low
  p_frame_ce_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld_o |-> !ce_d);
endmodule

// File: rtl/zcl_timer.sv
module zcl_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [TMR_W-1:0] limit_i,
  output logic             expired_o
);
  logic             running_q;
  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W:0]   next_cnt;

  assign next_cnt  = {1'b0, cnt_q} + 1'b1;
  assign expired_o = running_q && (next_cnt >= {1'b0, limit_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
    end else if (start_i) begin
      running_q <= 1'b1;
      cnt_q     <= '0;
    end else if (stop_i) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
    end else if (running_q && (cnt_q != '1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/zcl_apply_ctrl.sv
module zcl_apply_ctrl
  import zcl_pkg::*;
#(
  parameter int               PAY_W   = 8,
  parameter int               TMR_W   = 24,
  parameter logic [PAY_W-1:0] RST_PAY = '0,
  localparam int              FRAME_W = PAY_W + MODE_W + SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_vld_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               zc_pulse_i,
  input  logic [TMR_W-1:0]   timeout_i,
  output logic [SEL_W-1:0]   det_point_o,
  output logic               zc_mode_o,
  output logic               apply_stb_o,
  output logic [PAY_W-1:0]   payload_o
);
  ctl_fields_t      ctl;
  logic [PAY_W-1:0] new_pay, pend_pay_q;
  logic             pending_q, wait_mode, expired;
  logic             fire_pending, apply_now, tmr_start;

  assign new_pay = frame_i[FRAME_W-1 -: PAY_W];
  assign ctl     = frame_i[MODE_W+SEL_W-1:0];
  assign wait_mode = (ctl.mode == MODE_ZC_WAIT);

  assign fire_pending = pending_q && (zc_pulse_i || expired);
  assign apply_now    = frame_vld_i ? !wait_mode : fire_pending;
  assign tmr_start    = frame_vld_i && wait_mode;

  zcl_timer #(.TMR_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (tmr_start),
    .stop_i   (apply_now),
    .limit_i  (timeout_i),
    .expired_o(expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_point_o <= PT_SOURCE;
      zc_mode_o   <= 1'b0;
      pending_q   <= 1'b0;
      pend_pay_q  <= RST_PAY;
    end else if (frame_vld_i) begin
      det_point_o <= decode_point(ctl.sel);
      zc_mode_o   <= wait_mode;
      pending_q   <= wait_mode;
      pend_pay_q  <= new_pay;
    end else if (fire_pending) begin
      pending_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      payload_o   <= RST_PAY;
      apply_stb_o <= 1'b0;
    end else begin
      apply_stb_o <= apply_now;
      if (apply_now) payload_o <= frame_vld_i ? new_pay : pend_pay_q;
    end
  end

  // R3: the comparator select is always exactly one point
  p_point_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(det_point_o) == 1);
  // R4: an immediate-mode word never leaves anything pending
  p_direct_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld_i && !wait_mode |=> apply_stb_o && !pending_q);
  // R5: a crossing on a pending word applies it next
  p_zc_applies_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q && zc_pulse_i && !frame_vld_i |=> apply_stb_o && !pending_q);
  // R6: expiry applies the pending word
  p_timeout_applies_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q && expired && !frame_vld_i |=> apply_stb_o);
  // R7: output payload moves only with the strobe
  p_payload_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_stb_o |-> $stable(payload_o));
  // R9: no strobe without a reason
  p_no_idle_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pending_q && !frame_vld_i |=> !apply_stb_o);
endmodule

// File: rtl/zcl_latch_top.sv
module zcl_latch_top
  import zcl_pkg::*;
#(
  parameter int               PAY_W   = 8,
  parameter int               TMR_W   = 24,
  parameter int               SYNC_N  = 2,
  parameter logic [PAY_W-1:0] RST_PAY = '0,
  localparam int              FRAME_W = PAY_W + MODE_W + SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_i,
  input  logic             cl_i,
  input  logic             di_i,
  input  logic             zc_pulse_i,
  input  logic [TMR_W-1:0] timeout_i,
  output logic [3:0]       det_point_o,
  output logic             zc_mode_o,
  output logic             apply_stb_o,
  output logic [PAY_W-1:0] payload_o
);
  logic               frame_vld;
  logic [FRAME_W-1:0] frame;

  zcl_serial_rx #(.FRAME_W(FRAME_W), .SYNC_N(SYNC_N)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_i       (ce_i),
    .cl_i       (cl_i),
    .di_i       (di_i),
    .frame_vld_o(frame_vld),
    .frame_o    (frame)
  );

  zcl_apply_ctrl #(.PAY_W(PAY_W), .TMR_W(TMR_W), .RST_PAY(RST_PAY)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_vld_i(frame_vld),
    .frame_i    (frame),
    .zc_pulse_i (zc_pulse_i),
    .timeout_i  (timeout_i),
    .det_point_o(det_point_o),
    .zc_mode_o  (zc_mode_o),
    .apply_stb_o(apply_stb_o),
    .payload_o  (payload_o)
  );

  // R1: reset value of the select is the source point
  p_reset_point_r1: assert property (@(posedge clk)
    !rst_n |=> det_point_o == 4'b1000 || !rst_n);
endmodule

// File: tb/test_zcl_latch_top.sv
module test_zcl_latch_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_i = 1'b0, cl_i = 1'b0, di_i = 1'b0, zc_pulse_i = 1'b0;
  logic [23:0] timeout_i = 24'd10;
  logic [3:0]  det_point_o;
  logic        zc_mode_o, apply_stb_o;
  logic [7:0]  payload_o;
  int checks = 0, failures = 0, stb_total = 0;

  always #4 clk = ~clk;

  zcl_latch_top i_zcl_latch_top (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .cl_i(cl_i), .di_i(di_i),
    .zc_pulse_i(zc_pulse_i), .timeout_i(timeout_i), .det_point_o(det_point_o),
    .zc_mode_o(zc_mode_o), .apply_stb_o(apply_stb_o), .payload_o(payload_o));

  always @(negedge clk) if (apply_stb_o) stb_total++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  function automatic logic [3:0] exp_point(input logic [3:0] s);
    if (s != 0 && (s & (s - 4'd1)) == 0) return s;
    return 4'b1000;
  endfunction

  task automatic send_bits(input logic [13:0] w);
    ce_i = 1'b1; tick(); tick();
    for (int i = 13; i >= 0; i--) begin
      di_i = w[i]; cl_i = 1'b0; tick(); tick(); tick();
      cl_i = 1'b1; tick(); tick(); tick();
    end
    cl_i = 1'b0; tick(); tick();
  endtask

  // Drops chip enable, then watches strobes; zc_at: sample after which a crossing pulse is driven
  task automatic run_frame(input logic [13:0] w, input int zc_at, input int exp, input string tag);
    logic [7:0] old;
    int first, n;
    old = payload_o; first = 0; n = 0;
    send_bits(w);
    ce_i = 1'b0;
    for (int cyc = 1; cyc <= exp + 6; cyc++) begin
      tick();
      if (apply_stb_o) begin n++; if (first == 0) first = cyc; end
      if (cyc == exp - 1) chk(payload_o == old, "R7 payload held before strobe", payload_o, old);
      zc_pulse_i = (cyc == zc_at);
    end
    zc_pulse_i = 1'b0;
    chk(first == exp, {tag, " strobe cycle"}, first, exp);
    chk(n == 1, "R7 one strobe per word", n, 1);
    chk(payload_o == w[13:6], "R2 applied payload", payload_o, w[13:6]);
    chk(det_point_o == exp_point(w[3:0]), "R3 detection select", det_point_o, exp_point(w[3:0]));
    chk(zc_mode_o == (w[5:4] == 2'b00), "R3 mode flag", zc_mode_o, w[5:4] == 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s0, exp;
    logic [13:0] w;
    tick(); tick(); rst_n = 1'b1; tick();
    // R1 reset state
    chk(payload_o == 8'd0, "R1 payload", payload_o, 0);
    chk(det_point_o == 4'b1000, "R1 select", det_point_o, 8);
    chk(zc_mode_o == 1'b0, "R1 mode", zc_mode_o, 0);
    chk(apply_stb_o == 1'b0, "R1 strobe", apply_stb_o, 0);

    // R9: crossing with nothing pending
    s0 = stb_total;
    zc_pulse_i = 1'b1; tick(); zc_pulse_i = 1'b0; tick(); tick(); tick();
    chk(stb_total == s0, "R9 no strobe", stb_total - s0, 0);
    chk(payload_o == 8'd0, "R9 payload unchanged", payload_o, 0);

    // R4/R3: immediate mode over all select codes
    for (int s = 0; s < 16; s++) begin
      w = {8'(s * 17 + 3), 2'(s % 3 + 1), 4'(s)};
      run_frame(w, 0, 4, "R4");
    end

    // R6: timeout sweep in zero-cross mode
    for (int l = 0; l < 8; l++) begin
      timeout_i = 24'(l);
      exp = 4 + ((l < 1) ? 1 : l);
      run_frame({8'(8'hA0 + l), 2'b00, 4'b0001}, 0, exp, "R6");
    end

    // R5: crossing pulse at every position around the capture edge
    timeout_i = 24'd20;
    for (int z = 2; z <= 12; z++) begin
      exp = (z >= 4) ? z + 1 : 24;
      run_frame({8'(8'h40 + z * 5), 2'b00, (z % 2 == 0) ? 4'b0010 : 4'b0100}, z, exp, "R5");
    end

    // R8: second word replaces pending one and restarts the timeout
    timeout_i = 24'd300;
    send_bits({8'h11, 2'b00, 4'b0100});
    ce_i = 1'b0;
    repeat (100) tick();
    s0 = stb_total;
    run_frame({8'h5C, 2'b00, 4'b0010}, 0, 304, "R8");
    chk(stb_total - s0 == 1, "R8 first word never applied", stb_total - s0, 1);
    chk(payload_o == 8'h5C, "R8 replacing payload", payload_o, 8'h5C);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule